// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Multiply-Accumulate Unit

This block takes a single command and multiplies a chosen 3x3 matrix by a chosen three-element vector. The matrix elements are signed 16-bit values with 12 fraction bits. It can also add a chosen 32-bit translation vector, scaled by 4096. The three row sums become three 32-bit accumulator results and three clamped 16-bit intermediate results. The block also builds an error flag word that reports saturation and overflow.

Fields of a 25-bit command word select the operands, the fraction shift and the clamp floor. Every operand arrives on its own parallel port. The block keeps two selection quirks:
- When the far-colour translation is selected, each result keeps only the third product term. The overflow flags are still computed from the full sum.
- The reserved matrix code selects a fixed mix of constants and borrowed elements.

A start pulse accepted while the unit is idle loads the results and flags in the same edge. After that the unit reports busy for a fixed number of cycles and ignores any further start pulses.

Top module: `mvm_mac_unit`

## Requirements
- R1: Command bits 18:17 select the matrix: 0 picks `rot_m`, 1 picks `lgt_m`, 2 picks `col_m`. Code 3 picks a fixed matrix. In row-major order its elements are -0x60, +0x60, `ir0`, element 2 of `rot_m` three times, then element 4 of `rot_m` three times. Matrix element k (row-major, k=0..8) sits at bits [16k+15:16k].
- R2: Command bits 16:15 select the vector: 0 picks `vec0`, 1 picks `vec1`, 2 picks `vec2`, 3 picks `ir_vec`. Vector element j sits at bits [16j+15:16j].
- R3: Command bits 14:13 select the translation: 0 picks `tr_v`, 1 picks `bk_v`, 3 picks zero. Element i (bits [32i+31:32i]) is multiplied by 4096 and added to row i's three signed products. Command bits 24:20, 12:11 and 9:0 have no effect.
- R4: When command bit 19 is 1, the row sum is shifted arithmetically right by 12. When it is 0, the row sum is not shifted. The low 32 bits of the result go to `mac1`..`mac3` with no clamping.
- R5: `ir1`..`ir3` take the 32-bit result clamped to -0x8000..0x7FFF when command bit 10 is 0, and to 0..0x7FFF when it is 1. A clamp of row 1, 2 or 3 sets flag bit 24, 23 or 22 respectively.
- R6: A row sum, taken before the shift, that is at least 2^43 sets flag bit 30, 29 or 28 for row 1, 2 or 3. A row sum below -2^43 sets flag bit 27, 26 or 25.
- R7: Translation code 2 takes `fc_v` as the translation for the overflow flags only. In that case each result is the third product alone (matrix element 3i+2 times vector element 2), shifted as in R4.
- R8: Every accepted command replaces the whole flag word. Bit 31 is the OR of bits 30..23, which leaves out bit 22. Bits 21..0 are always zero.
- R9: An accepted start loads the results and flags at that edge. `busy` is then high for exactly 8 cycles, and `done` is high only in the last of those cycles.
- R10: A start pulse while `busy` is high is ignored. The outputs keep their values and the busy window is not extended.
- R11: After reset all result ports, the flag word, `busy` and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse |
| cmd | input | 25 | Command word |
| rot_m | input | 144 | Rotation matrix, 9 x s16 |
| lgt_m | input | 144 | Light matrix, 9 x s16 |
| col_m | input | 144 | Colour matrix, 9 x s16 |
| vec0 | input | 48 | Vector 0, 3 x s16 |
| vec1 | input | 48 | Vector 1, 3 x s16 |
| vec2 | input | 48 | Vector 2, 3 x s16 |
| ir_vec | input | 48 | Intermediate triple used as a vector, 3 x s16 |
| ir0 | input | 16 | Interpolation value, used by the fixed matrix |
| tr_v | input | 96 | Translation vector, 3 x s32 |
| bk_v | input | 96 | Background colour vector, 3 x s32 |
| fc_v | input | 96 | Far colour vector, 3 x s32 |
| mac1 | output | 32 | Row 1 accumulator |
| mac2 | output | 32 | Row 2 accumulator |
| mac3 | output | 32 | Row 3 accumulator |
| ir1 | output | 16 | Row 1 clamped result |
| ir2 | output | 16 | Row 2 clamped result |
| ir3 | output | 16 | Row 3 clamped result |
| flags | output | 32 | Error flag word |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last busy cycle |

## Verification
The assertions check the following on every cycle:
- the busy/done sequencing and that results hold still during the busy window;
- that `ir1` equals the low half of `mac1` whenever no clamp was flagged;
- that the clamp floor of 0 is respected;
- that the positive and negative overflow flags never coincide;
- that bit 31 and the unused bits of the flag word are consistent.

Only the bench's scenarios can show that the selections and arithmetic are correct. The bench sweeps every combination of matrix, vector, translation, shift and floor codes over several operand sets, including sets that overflow 43 bits in each direction. Only those scenarios show the far-colour truncation, the contents of the fixed reserved matrix, and that a start pulse during the busy window is dropped.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  localparam int EW   = 16;  // matrix/vector element width
  localparam int TW   = 32;  // translation element width
  localparam int AW   = 32;  // accumulator output width
  localparam int SW   = 48;  // internal sum width
  localparam int OVB  = 43;  // overflow threshold bit
  localparam int FRAC = 12;  // fraction bits

  localparam logic signed [SW-1:0] OV_MAX = {{(SW-OVB){1'b0}}, {OVB{1'b1}}};
  localparam logic signed [SW-1:0] OV_MIN = {{(SW-OVB){1'b1}}, {OVB{1'b0}}};
  localparam logic signed [AW-1:0] IR_HI  = {{(AW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [AW-1:0] IR_LO  = {{(AW-EW+1){1'b1}}, {(EW-1){1'b0}}};

  typedef struct packed {
    logic [AW-1:0] mac;
    logic [EW-1:0] ir;
    logic          ovp;
    logic          ovn;
    logic          sat;
  } row_res_t;

  function automatic logic signed [SW-1:0] sx_prod(input logic signed [EW-1:0] a,
                                                   input logic signed [EW-1:0] b);
    logic signed [2*EW-1:0] p;
    p = a * b;
    return {{(SW-2*EW){p[2*EW-1]}}, p};
  endfunction

  function automatic row_res_t row_eval(input logic signed [TW-1:0] t,
                                        input logic signed [EW-1:0] m1, m2, m3,
                                        input logic signed [EW-1:0] x1, x2, x3,
                                        input logic sf, input logic lm, input logic trunc);
    logic signed [SW-1:0] tx, full, tail, scaled;
    logic signed [AW-1:0] macv;
    row_res_t r;
    tx     = {{(SW-TW){t[TW-1]}}, t};
    full   = (tx <<< FRAC) + sx_prod(m1, x1) + sx_prod(m2, x2) + sx_prod(m3, x3);
    tail   = trunc ? sx_prod(m3, x3) : full;
    scaled = sf ? (tail >>> FRAC) : tail;
    macv   = scaled[AW-1:0];
    r.mac  = macv;
    r.ovp  = (full > OV_MAX);
    r.ovn  = (full < OV_MIN);
    if (macv > IR_HI) begin
      r.ir = IR_HI[EW-1:0]; r.sat = 1'b1;
    end else if (lm && (macv < 0)) begin
      r.ir = '0; r.sat = 1'b1;
    end else if (!lm && (macv < IR_LO)) begin
      r.ir = IR_LO[EW-1:0]; r.sat = 1'b1;
    end else begin
      r.ir = macv[EW-1:0]; r.sat = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/mvm_sel.sv
module mvm_sel
  import mvm_pkg::*;
(
  input  logic [1:0]      mx,
  input  logic [1:0]      vx,
  input  logic [1:0]      cv,
  input  logic [9*EW-1:0] rot_m,
  input  logic [9*EW-1:0] lgt_m,
  input  logic [9*EW-1:0] col_m,
  input  logic [3*EW-1:0] vec0,
  input  logic [3*EW-1:0] vec1,
  input  logic [3*EW-1:0] vec2,
  input  logic [3*EW-1:0] ir_vec,
  input  logic [EW-1:0]   ir0,
  input  logic [3*TW-1:0] tr_v,
  input  logic [3*TW-1:0] bk_v,
  input  logic [3*TW-1:0] fc_v,
  output logic [9*EW-1:0] mat,
  output logic [3*EW-1:0] vec,
  output logic [3*TW-1:0] trn,
  output logic            trunc
);
  localparam logic [EW-1:0] GARB_NEG = -EW'(16'h0060);
  localparam logic [EW-1:0] GARB_POS = EW'(16'h0060);

  logic [EW-1:0] rt13, rt22;
  logic [9*EW-1:0] garbage;

  assign rt13    = rot_m[2*EW +: EW];
  assign rt22    = rot_m[4*EW +: EW];
  assign garbage = {rt22, rt22, rt22, rt13, rt13, rt13, ir0, GARB_POS, GARB_NEG};

  always_comb begin
    unique case (mx)
      2'd0:    mat = rot_m;
      2'd1:    mat = lgt_m;
      2'd2:    mat = col_m;
      default: mat = garbage;
    endcase
    unique case (vx)
      2'd0:    vec = vec0;
      2'd1:    vec = vec1;
      2'd2:    vec = vec2;
      default: vec = ir_vec;
    endcase
    unique case (cv)
      2'd0:    trn = tr_v;
      2'd1:    trn = bk_v;
      2'd2:    trn = fc_v;
      default: trn = '0;
    endcase
  end

  assign trunc = (cv == 2'd2);
endmodule

// File: rtl/mvm_seq.sv
module mvm_seq #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_DONE_IN_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);                // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);              // R9
  AST_START_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) accept |=> (busy && !done));   // R9
endmodule

// File: rtl/mvm_mac_unit.sv
module mvm_mac_unit
  import mvm_pkg::*;
#(
  parameter int CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [24:0]       cmd,
  input  logic [9*EW-1:0]   rot_m,
  input  logic [9*EW-1:0]   lgt_m,
  input  logic [9*EW-1:0]   col_m,
  input  logic [3*EW-1:0]   vec0,
  input  logic [3*EW-1:0]   vec1,
  input  logic [3*EW-1:0]   vec2,
  input  logic [3*EW-1:0]   ir_vec,
  input  logic [EW-1:0]     ir0,
  input  logic [3*TW-1:0]   tr_v,
  input  logic [3*TW-1:0]   bk_v,
  input  logic [3*TW-1:0]   fc_v,
  output logic [AW-1:0]     mac1,
  output logic [AW-1:0]     mac2,
  output logic [AW-1:0]     mac3,
  output logic [EW-1:0]     ir1,
  output logic [EW-1:0]     ir2,
  output logic [EW-1:0]     ir3,
  output logic [31:0]       flags,
  output logic              busy,
  output logic              done
);
  localparam int ROWS = 3;

  logic            sf, lm, accept, trunc;
  logic [9*EW-1:0] mat;
  logic [3*EW-1:0] vec;
  logic [3*TW-1:0] trn;
  row_res_t        rr [ROWS];
  logic [31:0]     flags_nxt;
  logic [AW-1:0]   mac_q [ROWS];
  logic [EW-1:0]   ir_q  [ROWS];
  logic            lm_q;

  assign sf = cmd[19];
  assign lm = cmd[10];

  mvm_sel u_sel (
    .mx(cmd[18:17]), .vx(cmd[16:15]), .cv(cmd[14:13]),
    .rot_m(rot_m), .lgt_m(lgt_m), .col_m(col_m),
    .vec0(vec0), .vec1(vec1), .vec2(vec2), .ir_vec(ir_vec), .ir0(ir0),
    .tr_v(tr_v), .bk_v(bk_v), .fc_v(fc_v),
    .mat(mat), .vec(vec), .trn(trn), .trunc(trunc)
  );

  mvm_seq #(.CYCLES(CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .busy(busy), .done(done)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign rr[g] = row_eval(trn[g*TW +: TW],
                            mat[(3*g)*EW +: EW], mat[(3*g+1)*EW +: EW], mat[(3*g+2)*EW +: EW],
                            vec[0 +: EW], vec[EW +: EW], vec[2*EW +: EW],
                            sf, lm, trunc);
  end

  always_comb begin
    flags_nxt = '0;
    for (int i = 0; i < ROWS; i++) begin
      flags_nxt[30-i] = rr[i].ovp;
      flags_nxt[27-i] = rr[i].ovn;
      flags_nxt[24-i] = rr[i].sat;
    end
    flags_nxt[31] = |flags_nxt[30:23];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        mac_q[i] <= '0;
        ir_q[i]  <= '0;
      end
      flags <= '0;
      lm_q  <= 1'b0;
    end else if (accept) begin
      for (int i = 0; i < ROWS; i++) begin
        mac_q[i] <= rr[i].mac;
        ir_q[i]  <= rr[i].ir;
      end
      flags <= flags_nxt;
      lm_q  <= lm;
    end
  end

  assign mac1 = mac_q[0];
  assign mac2 = mac_q[1];
  assign mac3 = mac_q[2];
  assign ir1  = ir_q[0];
  assign ir2  = ir_q[1];
  assign ir3  = ir_q[2];

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(mac1) && $stable(ir3) && $stable(flags)));              // R10
  AST_IR_FOLLOWS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flags[24]) |-> (ir1 == mac1[EW-1:0]));                                     // R5
  AST_LM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lm_q) |-> (!ir1[EW-1] && !ir2[EW-1] && !ir3[EW-1]));                        // R5
  AST_OVF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!(flags[30] && flags[27]) && !(flags[28] && flags[25])));                  // R6
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((flags[31] == |flags[30:23]) && (flags[21:0] == 22'h0)));                  // R8
endmodule

// File: tb/mvm_mac_unit_tb.sv
module mvm_mac_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [24:0] cmd = '0;
  logic [15:0] rot [9], lgt [9], col [9];
  logic [15:0] vv [4][3];   // index 3 is the IR triple
  logic [15:0] ir0v;
  logic [31:0] trs [3][3];  // 0 TR, 1 BK, 2 FC
  logic [143:0] rot_p, lgt_p, col_p;
  logic [47:0]  v0_p, v1_p, v2_p, irv_p;
  logic [95:0]  tr_p, bk_p, fc_p;
  logic [31:0] mac1, mac2, mac3, flags;
  logic [15:0] ir1, ir2, ir3;
  logic busy, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < 9; k++) begin
      rot_p[k*16 +: 16] = rot[k];
      lgt_p[k*16 +: 16] = lgt[k];
      col_p[k*16 +: 16] = col[k];
    end
    for (int j = 0; j < 3; j++) begin
      v0_p[j*16 +: 16]  = vv[0][j];
      v1_p[j*16 +: 16]  = vv[1][j];
      v2_p[j*16 +: 16]  = vv[2][j];
      irv_p[j*16 +: 16] = vv[3][j];
      tr_p[j*32 +: 32]  = trs[0][j];
      bk_p[j*32 +: 32]  = trs[1][j];
      fc_p[j*32 +: 32]  = trs[2][j];
    end
  end

  mvm_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .rot_m(rot_p), .lgt_m(lgt_p), .col_m(col_p),
    .vec0(v0_p), .vec1(v1_p), .vec2(v2_p), .ir_vec(irv_p), .ir0(ir0v),
    .tr_v(tr_p), .bk_v(bk_p), .fc_v(fc_p),
    .mac1(mac1), .mac2(mac2), .mac3(mac3),
    .ir1(ir1), .ir2(ir2), .ir3(ir3),
    .flags(flags), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h cmd=%h", tag, what, act, exp, cmd);
    end
  endtask

  function automatic longint s16(input logic [15:0] x);
    return longint'($signed(x));
  endfunction

  logic [31:0] e_mac [3];
  logic [15:0] e_ir  [3];
  logic [31:0] e_flags;

  task automatic expect_cmd(input logic [24:0] c);
    longint me [9];
    longint ve [3];
    longint te, full, part, lim;
    logic [1:0] mx, vx, cv;
    logic sf, lm;
    logic signed [31:0] mv;
    mx = c[18:17]; vx = c[16:15]; cv = c[14:13]; sf = c[19]; lm = c[10];
    for (int k = 0; k < 9; k++) begin
      case (mx)
        2'd0: me[k] = s16(rot[k]);
        2'd1: me[k] = s16(lgt[k]);
        2'd2: me[k] = s16(col[k]);
        default: me[k] = (k == 0) ? -96 : (k == 1) ? 96 : (k == 2) ? s16(ir0v) :
                         (k < 6) ? s16(rot[2]) : s16(rot[4]);
      endcase
    end
    for (int j = 0; j < 3; j++) ve[j] = s16(vv[vx][j]);
    lim = longint'(1) <<< 43;
    e_flags = '0;
    for (int i = 0; i < 3; i++) begin
      te   = (cv == 2'd3) ? 0 : longint'($signed(trs[cv][i]));
      full = te * 4096 + me[3*i]*ve[0] + me[3*i+1]*ve[1] + me[3*i+2]*ve[2];
      part = (cv == 2'd2) ? me[3*i+2]*ve[2] : full;
      if (sf) part = part >>> 12;
      e_mac[i] = part[31:0];
      mv = $signed(e_mac[i]);
      if (mv > 32767)              begin e_ir[i] = 16'h7FFF; e_flags[24-i] = 1'b1; end
      else if (lm && mv < 0)       begin e_ir[i] = 16'h0000; e_flags[24-i] = 1'b1; end
      else if (!lm && mv < -32768) begin e_ir[i] = 16'h8000; e_flags[24-i] = 1'b1; end
      else e_ir[i] = mv[15:0];
      if (full >= lim)  e_flags[30-i] = 1'b1;
      if (full < -lim)  e_flags[27-i] = 1'b1;
    end
    e_flags[31] = |e_flags[30:23];
  endtask

  task automatic check_results(input logic [24:0] c);
    string mt;
    if (c[14:13] == 2'd2)      mt = "R7";
    else if (c[18:17] == 2'd3) mt = "R1";
    else if (c[16:15] == 2'd3) mt = "R2";
    else if (c[19])            mt = "R4";
    else                       mt = "R3";
    chk(mt, "mac1", mac1, e_mac[0]);
    chk(mt, "mac2", mac2, e_mac[1]);
    chk(mt, "mac3", mac3, e_mac[2]);
    chk("R5", "ir1", {16'h0, ir1}, {16'h0, e_ir[0]});
    chk("R5", "ir2", {16'h0, ir2}, {16'h0, e_ir[1]});
    chk("R5", "ir3", {16'h0, ir3}, {16'h0, e_ir[2]});
    chk("R6", "flags", flags, e_flags);
    chk("R8", "flag31/unused", {flags[31], 9'h0, flags[21:0]}, {|flags[30:23], 31'h0});
  endtask

  // Issues a command, counts busy cycles up to done; optionally injects a start mid-window.
  task automatic run_cmd(input logic [24:0] c, input bit inject, output int nbusy);
    @(negedge clk);
    cmd = c; start = 1'b1;
    expect_cmd(c);
    @(negedge clk);
    start = 1'b0;
    nbusy = 0;
    for (int w = 0; w < 40; w++) begin
      if (busy) nbusy++;
      if (done) break;
      if (inject && w == 2) begin
        cmd = c ^ 25'h0086000;
        rot[0] = rot[0] + 16'h1234;
        trs[0][0] = trs[0][0] ^ 32'h0F0F_0000;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    cmd = c;
  endtask

  task automatic load_set(input int s);
    for (int k = 0; k < 9; k++) begin
      case (s)
        0: begin rot[k] = 16'(k*37+1); lgt[k] = 16'(-(k*21+3)); col[k] = 16'(k*11+200); end
        1: begin rot[k] = 16'h8000; lgt[k] = 16'h8000; col[k] = 16'h7FFF; end
        2: begin rot[k] = 16'($urandom); lgt[k] = 16'($urandom); col[k] = 16'($urandom); end
        default: begin rot[k] = 16'h7FFF; lgt[k] = 16'h7FFF; col[k] = 16'h8001; end
      endcase
    end
    for (int j = 0; j < 3; j++) begin
      for (int q = 0; q < 4; q++) begin
        case (s)
          0: vv[q][j] = 16'(q*50 + j*7 + 5);
          1: vv[q][j] = 16'h8000;
          2: vv[q][j] = 16'($urandom);
          default: vv[q][j] = 16'h8000;
        endcase
      end
      for (int q = 0; q < 3; q++) begin
        case (s)
          0: trs[q][j] = 32'(q*1000 - j*333);
          1: trs[q][j] = 32'h7FFF_FFFF;
          2: trs[q][j] = $urandom;
          default: trs[q][j] = 32'h8000_0000;
        endcase
      end
    end
    ir0v = (s == 0) ? 16'h0800 : 16'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    logic [24:0] c;
    load_set(0);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "mac1", mac1, 32'h0);
    chk("R11", "ir3", {16'h0, ir3}, 32'h0);
    chk("R11", "flags", flags, 32'h0);
    chk("R11", "busy/done", {30'h0, busy, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle after reset", {31'h0, busy}, 32'h0);

    for (int s = 0; s < 4; s++) begin
      load_set(s);
      for (int n = 0; n < 256; n++) begin
        c = 25'h0;
        c[24:20] = 5'(n);          // ignored field (R3)
        c[18:17] = n[1:0];
        c[16:15] = n[3:2];
        c[14:13] = n[5:4];
        c[19]    = n[6];
        c[10]    = n[7];
        c[5:0]   = 6'h12;
        c[12:11] = 2'(n >> 2);     // ignored field (R3)
        run_cmd(c, 1'b0, nb);
        if (n == 0) chk("R9", "busy length", nb, 8);
        check_results(c);
      end
    end

    // R10: start during busy is dropped
    load_set(2);
    c = 25'h0080412;  // sf=1, lm=1, rotation, V0, TR
    run_cmd(c, 1'b1, nb);
    chk("R10", "busy length with injected start", nb, 8);
    check_results(c);
    @(negedge clk);
    chk("R10", "idle after window", {31'h0, busy}, 32'h0);
    chk("R10", "mac1 held", mac1, e_mac[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule